// File: doc/BRIEF.md
# Counter Array Timebase and Interrupt Combiner

This block holds the shared free-running 16-bit timebase of a programmable counter array, in which five capture/compare modules sit. It also gathers their event reports into one interrupt request. Software reaches its registers over a byte-wide read/write bus with a combinational read path. The counter advances on a count-enable input while software has set the run bit. It can be frozen while the system is idle. It raises a sticky overflow flag each time it wraps.

Each module reports a match or a capture as a one-cycle pulse on its event input. The pulse latches a sticky flag that only software can clear, by writing 0 to that flag bit. The overflow flag and the five module flags are each gated by their own enable, and the gated sources are ORed onto one request line. A watchdog-enable bit for module 4 is held here and driven out as a pin.

Register map (byte addresses): 0 = control, 1 = mode, 2 = module interrupt enables (bit n enables module n), 4 = counter low byte, 5 = counter high byte. Unmapped addresses read 0x00. In the control register, bit 7 is the overflow flag, bit 6 is the run bit, and bits 4..0 are the module flags. In the mode register, bit 0 enables the overflow interrupt, bit 6 is the watchdog enable and bit 7 is the idle-stop bit. Unlisted bits read 0.

Top module: `cntarr_ctl`

## Requirements
- R1: The counter increments by one on each clock edge where the run bit (control bit 6) is 1 and count_en_i is 1. With either at 0 it holds its value.
- R2: While the idle-stop bit (mode bit 7) is 1 and idle_i is 1, the counter holds. With idle-stop at 0, idle_i has no effect on counting.
- R3: The overflow flag (control bit 7) becomes 1 in the cycle after the counter advances from 0xFFFF to 0x0000. Further counting never clears it. Writing 1 to it leaves it unchanged, and writing 0 clears it.
- R4: A pulse on mod_evt_i[n] sets module flag n (control bit n, n = 0..4) on the next edge. Writing 0 to the bit clears it. Writing 1 to it has no effect.
- R5: When a module event and a software write clearing the same flag occur in the same cycle, the flag ends up 1.
- R6: irq_o is 1 exactly when (overflow flag AND mode bit 0) or, for some n, (module flag n AND enable register bit n).
- R7: wdog_en_o equals mode bit 6, which reads back as written.
- R8: The counter bytes at addresses 4 (low) and 5 (high) read the current count. A write to either byte loads that byte and takes priority over counting in the same cycle, so that cycle neither increments nor wraps.
- R9: After reset every register reads 0x00, and irq_o and wdog_en_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_en_i | input | 1 | Count tick for the timebase |
| idle_i | input | 1 | System idle indication |
| mod_evt_i | input | 5 | Per-module match/capture event pulses |
| reg_addr_i | input | 3 | Register byte address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| irq_o | output | 1 | Combined interrupt request |
| wdog_en_o | output | 1 | Watchdog enable for module 4 |

## Verification
The hardest situations to reach are the wrap from 0xFFFF and a collision between a hardware flag set and a software clear. Counting up to the wrap would take 65536 ticks, so the stimulus instead loads 0xFFFF through the two counter byte writes while the run bit is 0, and then lets exactly one tick through. The collision is produced by driving an event pulse in the same cycle as a control write of zero. A second flag that is already set is cleared by that same write, which shows that the write itself took effect.

// File: rtl/cntarr_pkg.sv
package cntarr_pkg;
  // register byte addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_MODE = 1;
  localparam int ADDR_MIE  = 2;
  localparam int ADDR_CNT0 = 4; // counter bytes, least significant first

  // control register bit positions
  localparam int CTRL_OVF = 7;
  localparam int CTRL_RUN = 6;

  // mode register bit positions
  localparam int MODE_OVFIE = 0;
  localparam int MODE_WDOG  = 6;
  localparam int MODE_IDLE  = 7;
endpackage

// File: rtl/cntarr_counter.sv
module cntarr_counter #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv_i,
  input  logic [CNT_W/8-1:0]   wr_byte_i,
  input  logic [7:0]           wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 wrap_o
);
  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             wrap;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (|wr_byte_i) begin
      for (int k = 0; k < NB; k++) begin
        if (wr_byte_i[k]) cnt_d[k*8 +: 8] = wdata_i;
      end
    end else if (adv_i) begin
      {wrap, cnt_d} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    end
  end

  assign cnt_en = adv_i | (|wr_byte_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap;
endmodule

// File: rtl/cntarr_flags.sv
module cntarr_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         wr_i,
  input  logic [N-1:0] keep_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic d, en;
    // set has priority; a written 0 clears, a written 1 keeps
    always_comb begin
      en = set_i[i] | wr_i;
      d  = set_i[i] | (flag_q[i] & keep_i[i]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[i] <= 1'b0;
      else if (en) flag_q[i] <= d;
    end
  end

  assign flags_o = flag_q;
endmodule

// File: rtl/cntarr_irq.sv
module cntarr_irq #(
  parameter int N = 5
) (
  input  logic         ovf_i,
  input  logic         ovf_en_i,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic [N:0] src;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign src[i] = flags_i[i] & en_i[i];
  end
  assign src[N] = ovf_i & ovf_en_i;

  assign irq_o = |src;
endmodule

// File: rtl/cntarr_ctl.sv
module cntarr_ctl
  import cntarr_pkg::*;
#(
  parameter int NMOD   = 5,   // at most 6: module flags sit below the run bit
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en_i,
  input  logic              idle_i,
  input  logic [NMOD-1:0]   mod_evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  output logic              wdog_en_o
);
  localparam int NB = CNT_W / 8;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  // write decode
  logic          ctrl_wr, mode_wr, mie_wr;
  logic [NB-1:0] cnt_wr_byte;
  logic          cnt_wr;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign mode_wr = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_MODE));
  assign mie_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_MIE));

  for (genvar k = 0; k < NB; k++) begin : g_cwr
    assign cnt_wr_byte[k] = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_CNT0 + k));
  end
  assign cnt_wr = |cnt_wr_byte;

  // control and mode state
  logic            run_q, run_d;
  logic            ovfie_q, ovfie_d;
  logic            wdog_q, wdog_d;
  logic            idles_q, idles_d;
  logic [NMOD-1:0] mie_q, mie_d;
  logic            cfg_en;

  always_comb begin
    run_d   = run_q;
    ovfie_d = ovfie_q;
    wdog_d  = wdog_q;
    idles_d = idles_q;
    mie_d   = mie_q;
    if (ctrl_wr) run_d = reg_wdata_i[CTRL_RUN];
    if (mode_wr) begin
      ovfie_d = reg_wdata_i[MODE_OVFIE];
      wdog_d  = reg_wdata_i[MODE_WDOG];
      idles_d = reg_wdata_i[MODE_IDLE];
    end
    if (mie_wr) mie_d = reg_wdata_i[NMOD-1:0];
  end

  assign cfg_en = ctrl_wr | mode_wr | mie_wr;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      run_q   <= 1'b0;
      ovfie_q <= 1'b0;
      wdog_q  <= 1'b0;
      idles_q <= 1'b0;
      mie_q   <= '0;
    end else if (cfg_en) begin
      run_q   <= run_d;
      ovfie_q <= ovfie_d;
      wdog_q  <= wdog_d;
      idles_q <= idles_d;
      mie_q   <= mie_d;
    end
  end

  // timebase
  logic             adv;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign adv = run_q & count_en_i & ~(idles_q & idle_i);

  cntarr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .adv_i     (adv),
    .wr_byte_i (cnt_wr_byte),
    .wdata_i   (reg_wdata_i),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  // sticky flags
  logic [NMOD-1:0] mflags;
  logic            ovf;

  cntarr_flags #(.N(NMOD)) u_mflags (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .set_i   (mod_evt_i),
    .wr_i    (ctrl_wr),
    .keep_i  (reg_wdata_i[NMOD-1:0]),
    .flags_o (mflags)
  );

  cntarr_flags #(.N(1)) u_oflag (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .set_i   (wrap),
    .wr_i    (ctrl_wr),
    .keep_i  (reg_wdata_i[CTRL_OVF]),
    .flags_o (ovf)
  );

  cntarr_irq #(.N(NMOD)) u_irq (
    .ovf_i    (ovf),
    .ovf_en_i (ovfie_q),
    .flags_i  (mflags),
    .en_i     (mie_q),
    .irq_o    (irq_o)
  );

  // read path
  always_comb begin
    reg_rdata_o = 8'h00;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL)) begin
      reg_rdata_o[CTRL_OVF]  = ovf;
      reg_rdata_o[CTRL_RUN]  = run_q;
      reg_rdata_o[NMOD-1:0]  = mflags;
    end else if (reg_addr_i == ADDR_W'(ADDR_MODE)) begin
      reg_rdata_o[MODE_OVFIE] = ovfie_q;
      reg_rdata_o[MODE_WDOG]  = wdog_q;
      reg_rdata_o[MODE_IDLE]  = idles_q;
    end else if (reg_addr_i == ADDR_W'(ADDR_MIE)) begin
      reg_rdata_o[NMOD-1:0] = mie_q;
    end
    for (int k = 0; k < NB; k++) begin
      if (reg_addr_i == ADDR_W'(ADDR_CNT0 + k)) reg_rdata_o = cnt[k*8 +: 8];
    end
  end

  assign wdog_en_o = wdog_q;
endmodule

// File: rtl/cntarr_ctl_chk.sv
module cntarr_ctl_chk #(
  parameter int NMOD  = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             count_en,
  input logic             idle,
  input logic             idle_stop,
  input logic             cnt_wr,
  input logic             ctrl_wr,
  input logic             wdata_ovf,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic [NMOD-1:0]  mod_evt,
  input logic [NMOD-1:0]  flags,
  input logic [NMOD-1:0]  mie,
  input logic             ovf_ie,
  input logic             irq
);
  logic halted;
  assign halted = !run || !count_en || (idle_stop && idle);

  // R1: stopped or no tick keeps the count
  a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !count_en) && !cnt_wr |=> $stable(cnt));

  // R2: idle with idle-stop freezes the count
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle_stop && idle && !cnt_wr |=> $stable(cnt));

  // R3: wrap sets the overflow flag
  a_r3_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !halted && !cnt_wr && (cnt == {CNT_W{1'b1}}) |=> ovf && (cnt == '0));

  // R3: overflow flag drops only on a software write of 0
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(ctrl_wr && !wdata_ovf) |=> ovf);

  // R4 / R5: an event always leaves its flag set
  a_r4_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_evt != '0) |=> ((flags & $past(mod_evt)) == $past(mod_evt)));

  // R4: a flag never rises without an event
  a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((flags & ~$past(flags) & ~$past(mod_evt)) == '0));

  // R6: no enabled source, no request
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & mie) == '0) && !(ovf && ovf_ie) |-> !irq);

  // R6: an enabled overflow raises the request
  a_r6_irq_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && ovf_ie |-> irq);
endmodule

bind cntarr_ctl cntarr_ctl_chk #(.NMOD(NMOD), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .run       (run_q),
  .count_en  (count_en_i),
  .idle      (idle_i),
  .idle_stop (idles_q),
  .cnt_wr    (cnt_wr),
  .ctrl_wr   (ctrl_wr),
  .wdata_ovf (reg_wdata_i[7]),
  .cnt       (cnt),
  .ovf       (ovf),
  .mod_evt   (mod_evt_i),
  .flags     (mflags),
  .mie       (mie_q),
  .ovf_ie    (ovfie_q),
  .irq       (irq_o)
);

// File: tb/cntarr_ctl_bench.sv
`timescale 1ns/1ps
module cntarr_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       count_en;
  logic       idle;
  logic [4:0] mod_evt;
  logic [2:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       wdog_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  cntarr_ctl u_cntarr_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .count_en_i  (count_en),
    .idle_i      (idle),
    .mod_evt_i   (mod_evt),
    .reg_addr_i  (reg_addr),
    .reg_wr_i    (reg_wr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq),
    .wdog_en_o   (wdog_en)
  );

  // {events[4:0], enables[4:0], expected irq}
  localparam logic [10:0] VEC [0:7] = '{
    {5'b00001, 5'b00001, 1'b1},
    {5'b00010, 5'b00001, 1'b0},
    {5'b10000, 5'b10000, 1'b1},
    {5'b01010, 5'b10101, 1'b0},
    {5'b01010, 5'b01000, 1'b1},
    {5'b11111, 5'b00000, 1'b0},
    {5'b00000, 5'b11111, 1'b0},
    {5'b10100, 5'b00100, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    count_en = 1'b1;
    repeat (n) @(negedge clk);
    count_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] e);
    mod_evt = e;
    @(negedge clk);
    mod_evt = 5'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all_zero(input string tag);
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R9", $sformatf("%s reg %0d", tag, a), 32'(v), 32'h00);
    end
    check("R9", {tag, " irq"}, 32'(irq), 32'h0);
    check("R9", {tag, " wdog"}, 32'(wdog_en), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, lo, hi;
    count_en  = 1'b0;
    idle      = 1'b0;
    mod_evt   = 5'b0;
    reg_addr  = 3'd0;
    reg_wr    = 1'b0;
    reg_wdata = 8'h00;
    @(negedge clk);
    do_reset();

    check_all_zero("after reset");

    // R4 / R6: table of event patterns against enable masks
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 8'h00);
      wr(3'd2, {3'b0, VEC[i][5:1]});
      pulse(VEC[i][10:6]);
      rd(3'd0, v);
      check("R4", $sformatf("vec %0d flags", i), 32'(v), {27'b0, VEC[i][10:6]});
      check("R6", $sformatf("vec %0d irq", i), 32'(irq), {31'b0, VEC[i][0]});
    end
    wr(3'd2, 8'h00);

    // R5: set beats a simultaneous clear; the other flag is cleared
    wr(3'd0, 8'h00);
    pulse(5'b00101);
    mod_evt = 5'b00100;
    wr(3'd0, 8'h00);
    mod_evt = 5'b0;
    rd(3'd0, v);
    check("R5", "set wins over clear", 32'(v), 32'h04);

    // R4 / R3: writing ones sets nothing
    wr(3'd0, 8'h9F);
    rd(3'd0, v);
    check("R4", "write of ones ignored", 32'(v), 32'h04);
    wr(3'd0, 8'h00);

    // R1: counting under run and tick
    wr(3'd0, 8'h40);
    ticks(5);
    rd(3'd4, v);
    check("R1", "count after 5 ticks", 32'(v), 32'd5);
    repeat (4) @(negedge clk);
    rd(3'd4, v);
    check("R1", "hold without tick", 32'(v), 32'd5);
    wr(3'd0, 8'h00);
    ticks(4);
    rd(3'd4, v);
    check("R1", "hold with run 0", 32'(v), 32'd5);

    // R2: idle stop
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h80);
    idle = 1'b1;
    ticks(4);
    rd(3'd4, v);
    check("R2", "hold in idle", 32'(v), 32'd5);
    idle = 1'b0;
    ticks(2);
    rd(3'd4, v);
    check("R2", "count out of idle", 32'(v), 32'd7);
    wr(3'd1, 8'h00);
    idle = 1'b1;
    ticks(3);
    idle = 1'b0;
    rd(3'd4, v);
    check("R2", "idle ignored without stop", 32'(v), 32'd10);

    // R8: counter byte load while stopped
    wr(3'd0, 8'h00);
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    rd(3'd4, lo);
    rd(3'd5, hi);
    check("R8", "counter load", {16'b0, hi, lo}, 32'hFFFF);

    // R3: wrap sets overflow, request gated by mode bit 0
    wr(3'd0, 8'h40);
    ticks(1);
    rd(3'd4, lo);
    rd(3'd5, hi);
    check("R3", "count after wrap", {16'b0, hi, lo}, 32'h0000);
    rd(3'd0, v);
    check("R3", "overflow flag set", 32'(v), 32'hC0);
    check("R6", "irq masked", 32'(irq), 32'h0);
    wr(3'd1, 8'h01);
    check("R6", "irq on overflow", 32'(irq), 32'h1);
    ticks(3);
    rd(3'd0, v);
    check("R3", "flag kept while counting", 32'(v), 32'hC0);
    wr(3'd0, 8'hC0);
    rd(3'd0, v);
    check("R3", "write 1 keeps flag", 32'(v), 32'hC0);
    wr(3'd0, 8'h40);
    rd(3'd0, v);
    check("R3", "write 0 clears flag", 32'(v), 32'h40);
    check("R6", "irq after clear", 32'(irq), 32'h0);

    // R8: byte write takes priority over a tick
    count_en = 1'b1;
    wr(3'd4, 8'h20);
    count_en = 1'b0;
    rd(3'd4, v);
    check("R8", "write beats count", 32'(v), 32'h20);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    // R7: watchdog enable
    wr(3'd1, 8'h40);
    check("R7", "wdog pin", 32'(wdog_en), 32'h1);
    rd(3'd1, v);
    check("R7", "mode readback", 32'(v), 32'h40);

    // R9: reset with state loaded
    wr(3'd0, 8'h40);
    wr(3'd2, 8'h1F);
    pulse(5'b11111);
    do_reset();
    check_all_zero("mid-run reset");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule